// File: doc/BRIEF.md
# Four-Way Virtual-to-Physical Page Translator

This block holds 128 cached page translations in 4 ways of 32 sets and answers address lookups in the same cycle. A lookup presents a 32-bit virtual address, the current 8-bit address space identifier, and the access type (read or write, privileged or user). All four ways of the addressed set are compared at once. The result says whether exactly one way matched, none did, or several did. On a single match it also gives the physical address, the page attributes, a protection violation flag and a first-write flag.

Each stored translation describes either a 1 KB or a 4 KB page. It can be marked shared, so that it matches under any identifier. The block never fetches page tables itself. On a miss or a fault it only raises a flag, and a software handler refills entries through the write port, one entry per clock.

Top module: `xlat_tlb`

## Requirements
- R1: With `wr_en` high at a rising edge, the entry in way `wr_way`, set `wr_set` takes all write-port fields. Lookups from the next cycle on see the new contents, and other entries are unchanged.
- R2: A rising edge with `rst_n` low clears the valid bit of every entry, so every later lookup misses until entries are written again.
- R3: An entry with `wr_size`=0 is a 1 KB page. It matches only if lookup VA[11:10] equals its stored low bits. Its physical address is {ppn[21:0], VA[9:0]}.
- R4: An entry with `wr_size`=1 is a 4 KB page. VA[11:10] play no part in the compare. Its physical address is {ppn[21:2], VA[11:0]}.
- R5: An entry with the shared bit 0 matches only when its stored identifier equals `lk_asid`. An entry with the shared bit 1 ignores `lk_asid`.
- R6: `miss` is high when no valid entry of the set matches. An entry whose valid bit is 0 never matches. Exactly one of `hit`, `miss`, `multi_hit` is high at any time.
- R7: When two or more ways match, `multi_hit` is high and `hit` is low. In that case `pa`, the attributes, `prot_viol` and `first_write` are all zero. The same outputs are also zero on a miss.
- R8: Protection code bit 1 grants user access and bit 0 grants write access. So 00 is privileged read-only, 01 privileged read/write, 10 all-mode read-only and 11 all-mode read/write. On a hit, `prot_viol` is high for a user access without bit 1, or for a write without bit 0.
- R9: `first_write` is high on a hit that is a write, raises no violation, and lands on an entry whose dirty bit is 0.
- R10: On a hit, `attr_prot`, `attr_size`, `attr_cache`, `attr_dirty` and `attr_shared` show the matching entry's stored fields.
- R11: The set index is VA[16:12]. A match also needs VA[31:17] to equal the entry's stored high page bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, clears valid bits |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Current address space identifier |
| lk_write | input | 1 | Lookup is a write |
| lk_user | input | 1 | Lookup is from user mode |
| hit | output | 1 | Exactly one way matched |
| miss | output | 1 | No way matched |
| multi_hit | output | 1 | Several ways matched |
| pa | output | 32 | Translated physical address |
| attr_prot | output | 2 | Protection code of the hit entry |
| attr_size | output | 1 | Page size of the hit entry (1 = 4 KB) |
| attr_cache | output | 1 | Cacheable bit of the hit entry |
| attr_dirty | output | 1 | Dirty bit of the hit entry |
| attr_shared | output | 1 | Shared bit of the hit entry |
| prot_viol | output | 1 | Access breaks the page protection |
| first_write | output | 1 | Permitted write to a clean page |
| wr_en | input | 1 | Write strobe |
| wr_way | input | 2 | Way to write |
| wr_set | input | 5 | Set to write |
| wr_vpn_hi | input | 15 | Stored VA[31:17] |
| wr_vpn_lo | input | 2 | Stored VA[11:10] |
| wr_asid | input | 8 | Stored identifier |
| wr_valid | input | 1 | Stored valid bit |
| wr_ppn | input | 22 | Stored physical page number PA[31:10] |
| wr_prot | input | 2 | Stored protection code |
| wr_size | input | 1 | Stored page size |
| wr_cache | input | 1 | Stored cacheable bit |
| wr_dirty | input | 1 | Stored dirty bit |
| wr_shared | input | 1 | Stored shared bit |

## Verification
The bench looks up a 1 KB page with the wrong VA[11:10]. A design that always skipped the low-bit compare would hit there instead of missing. It also reads a 4 KB page whose stored PPN has nonzero low bits. A design that took PA[11:10] from the entry would return the wrong address. It sets up a 4 KB page and a 1 KB page that overlap in one set, which must raise `multi_hit` with `hit` low rather than letting one way win. It also checks a user write to a clean read-only page, which must fault without raising `first_write`. Lastly it places an invalid twin next to a live entry to catch a design that ignores the valid bit.

// File: rtl/tlb_pkg.sv
// Package: configuration and entry layout shared by the translator modules.
// Assumes a 32-bit virtual and physical address and a 1 KB minimum page.
package tlb_pkg;
    localparam int VA_W     = 32;
    localparam int WAYS     = 4;
    localparam int SETS     = 32;
    localparam int ASID_W   = 8;
    localparam int PG_SHIFT = 10;                      // 1 KB page offset width
    localparam int IDX_LSB  = 12;                      // set index starts above 4 KB offset
    localparam int WAY_W    = $clog2(WAYS);
    localparam int SET_W    = $clog2(SETS);
    localparam int HI_W     = VA_W - IDX_LSB - SET_W;  // stored high page bits
    localparam int LO_W     = IDX_LSB - PG_SHIFT;      // bits told apart only by 1 KB pages
    localparam int PPN_W    = VA_W - PG_SHIFT;

    typedef struct packed {
        logic [HI_W-1:0]   vpn_hi;
        logic [LO_W-1:0]   vpn_lo;
        logic [ASID_W-1:0] asid;
        logic              valid;
        logic [PPN_W-1:0]  ppn;
        logic [1:0]        prot;   // bit1: user allowed, bit0: writable
        logic              size;   // 1 = 4 KB page
        logic              cache;
        logic              dirty;
        logic              shared;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_way.sv
// Module: one way of the translator. Holds SETS entries, writes one per
// clock, and compares the addressed entry against the lookup tag.
// Assumes the write strobe is already decoded for this way.
module tlb_way
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  tlb_entry_t        wr_entry,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [HI_W-1:0]   lk_hi,
    input  logic [LO_W-1:0]   lk_lo,
    input  logic [ASID_W-1:0] lk_asid,
    output tlb_entry_t        rd_entry,
    output logic              match
);
    tlb_entry_t mem [SETS];

    // Purpose: store written entries; reset drops every valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) begin
                mem[i].valid <= 1'b0;
            end
        end else if (wr_en) begin
            mem[wr_set] <= wr_entry;
        end
    end

    // Purpose: read the indexed entry and test it against the lookup tag.
    always_comb begin
        rd_entry = mem[rd_set];
        match    = rd_entry.valid
                 && (rd_entry.vpn_hi == lk_hi)
                 && (rd_entry.size || (rd_entry.vpn_lo == lk_lo))
                 && (rd_entry.shared || (rd_entry.asid == lk_asid));
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(wr_set)] == $past(wr_entry))); // R1
endmodule

// File: rtl/tlb_resolve.sv
// Module: merges the per-way match results into the lookup outcome,
// forms the physical address and applies the protection rules.
// Assumes the entries presented all belong to the indexed set.
module tlb_resolve
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WAYS-1:0]  match,
    input  tlb_entry_t       ent [WAYS],
    input  logic [VA_W-1:0]  lk_va,
    input  logic             lk_write,
    input  logic             lk_user,
    output logic             hit,
    output logic             miss,
    output logic             multi_hit,
    output logic [VA_W-1:0]  pa,
    output tlb_entry_t       sel,
    output logic             prot_viol,
    output logic             first_write
);
    localparam int CNT_W = $clog2(WAYS + 1);

    logic [CNT_W-1:0] n_match;
    tlb_entry_t       pick;

    // Purpose: count matching ways and OR together the matching entries.
    always_comb begin
        n_match = '0;
        pick    = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) begin
                n_match = n_match + 1'b1;
                pick    = pick | ent[w];
            end
        end
    end

    // Purpose: classify the lookup and build address and flags.
    always_comb begin
        miss      = (n_match == '0);
        hit       = (n_match == CNT_W'(1));
        multi_hit = !miss && !hit;
        sel       = hit ? pick : '0;
        if (!hit)
            pa = '0;
        else if (sel.size)
            pa = {sel.ppn[PPN_W-1:LO_W], lk_va[IDX_LSB-1:0]};
        else
            pa = {sel.ppn, lk_va[PG_SHIFT-1:0]};
        prot_viol   = hit && ((lk_user && !sel.prot[1]) || (lk_write && !sel.prot[0]));
        first_write = hit && lk_write && !prot_viol && !sel.dirty;
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({hit, miss, multi_hit})); // R6
    AST_MULTI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        multi_hit |-> (pa == '0) && !prot_viol && !first_write); // R7
    AST_SMALL_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !sel.size) |-> (pa[PG_SHIFT-1:0] == lk_va[PG_SHIFT-1:0])); // R3
    AST_LARGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && sel.size) |-> (pa[IDX_LSB-1:0] == lk_va[IDX_LSB-1:0])); // R4
    AST_VIOL_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        prot_viol |-> hit && (lk_user || lk_write)); // R8
    AST_FW_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        first_write |-> hit && lk_write && !prot_viol && !sel.dirty); // R9
endmodule

// File: rtl/xlat_tlb.sv
// Module: top of the set-associative page translator. Splits the lookup
// address into index and tag, runs all ways in parallel, and resolves.
// Assumes refills come only through the write port, one per clock.
module xlat_tlb
    import tlb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] lk_va,
    input  logic [7:0]  lk_asid,
    input  logic        lk_write,
    input  logic        lk_user,
    output logic        hit,
    output logic        miss,
    output logic        multi_hit,
    output logic [31:0] pa,
    output logic [1:0]  attr_prot,
    output logic        attr_size,
    output logic        attr_cache,
    output logic        attr_dirty,
    output logic        attr_shared,
    output logic        prot_viol,
    output logic        first_write,
    input  logic        wr_en,
    input  logic [1:0]  wr_way,
    input  logic [4:0]  wr_set,
    input  logic [14:0] wr_vpn_hi,
    input  logic [1:0]  wr_vpn_lo,
    input  logic [7:0]  wr_asid,
    input  logic        wr_valid,
    input  logic [21:0] wr_ppn,
    input  logic [1:0]  wr_prot,
    input  logic        wr_size,
    input  logic        wr_cache,
    input  logic        wr_dirty,
    input  logic        wr_shared
);
    tlb_entry_t       wr_entry;
    tlb_entry_t       way_ent [WAYS];
    tlb_entry_t       sel;
    logic [WAYS-1:0]  way_match;
    logic [SET_W-1:0] lk_set;

    // Purpose: pack the write fields and slice the lookup address.
    always_comb begin
        wr_entry = '{vpn_hi: wr_vpn_hi, vpn_lo: wr_vpn_lo, asid: wr_asid,
                     valid: wr_valid, ppn: wr_ppn, prot: wr_prot,
                     size: wr_size, cache: wr_cache, dirty: wr_dirty,
                     shared: wr_shared};
        lk_set   = lk_va[IDX_LSB +: SET_W];
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tlb_way u_way (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en && (wr_way == WAY_W'(w))),
            .wr_set   (wr_set),
            .wr_entry (wr_entry),
            .rd_set   (lk_set),
            .lk_hi    (lk_va[VA_W-1 -: HI_W]),
            .lk_lo    (lk_va[PG_SHIFT +: LO_W]),
            .lk_asid  (lk_asid),
            .rd_entry (way_ent[w]),
            .match    (way_match[w])
        );
    end

    tlb_resolve u_res (
        .clk         (clk),
        .rst_n       (rst_n),
        .match       (way_match),
        .ent         (way_ent),
        .lk_va       (lk_va),
        .lk_write    (lk_write),
        .lk_user     (lk_user),
        .hit         (hit),
        .miss        (miss),
        .multi_hit   (multi_hit),
        .pa          (pa),
        .sel         (sel),
        .prot_viol   (prot_viol),
        .first_write (first_write)
    );

    // Purpose: expose the selected entry's attribute fields.
    always_comb begin
        attr_prot   = sel.prot;
        attr_size   = sel.size;
        attr_cache  = sel.cache;
        attr_dirty  = sel.dirty;
        attr_shared = sel.shared;
    end

    AST_RESET_EMPTY: assert property (@(posedge clk)
        $rose(rst_n) |-> miss && !hit); // R2
endmodule

// File: tb/xlat_tlb_tb_top.sv
// Bench: writes a fixed set of entries, walks a lookup vector table,
// then runs directed attribute, overwrite and reset checks.
module xlat_tlb_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] lk_va;
    logic [7:0]  lk_asid;
    logic        lk_write, lk_user;
    logic        hit, miss, multi_hit, prot_viol, first_write;
    logic [31:0] pa;
    logic [1:0]  attr_prot;
    logic        attr_size, attr_cache, attr_dirty, attr_shared;
    logic        wr_en, wr_valid, wr_size, wr_cache, wr_dirty, wr_shared;
    logic [1:0]  wr_way, wr_vpn_lo, wr_prot;
    logic [4:0]  wr_set;
    logic [14:0] wr_vpn_hi;
    logic [7:0]  wr_asid;
    logic [21:0] wr_ppn;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    xlat_tlb dut_i (.*);

    typedef struct packed {
        logic [31:0] va;
        logic [7:0]  asid;
        logic        wr, usr, e_hit, e_miss, e_multi;
        logic [31:0] e_pa;
        logic        e_viol, e_fw;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{32'h0002_1523, 8'h05, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0004_0123, 1'b0, 1'b0, 8'd3},  // R3 1 KB hit, R6 invalid twin ignored
        '{32'h0002_1523, 8'h05, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0004_0123, 1'b0, 1'b0, 8'd8},  // R8 all-mode RW, dirty page
        '{32'h0002_1923, 8'h05, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,         1'b0, 1'b0, 8'd3},  // R3 low bits differ
        '{32'h0002_1523, 8'h06, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,         1'b0, 1'b0, 8'd5},  // R5 wrong identifier
        '{32'h0004_1523, 8'h05, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,         1'b0, 1'b0, 8'd11}, // R11 high bits differ
        '{32'h0006_2ABC, 8'h99, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0008_1ABC, 1'b0, 1'b0, 8'd4},  // R4 R5 shared 4 KB
        '{32'h0006_2123, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0008_1123, 1'b0, 1'b0, 8'd4},  // R4 other low bits
        '{32'h0006_2ABC, 8'h99, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0008_1ABC, 1'b1, 1'b0, 8'd9},  // R9 faulting write, no flag
        '{32'h0006_3010, 8'h07, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0010_0010, 1'b0, 1'b1, 8'd9},  // R9 clean page write
        '{32'h0006_3010, 8'h07, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0010_0010, 1'b1, 1'b0, 8'd8},  // R8 user on privileged
        '{32'h0006_3010, 8'h07, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0010_0010, 1'b0, 1'b0, 8'd8},  // R8 privileged read
        '{32'h0006_3010, 8'h08, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,         1'b0, 1'b0, 8'd5},  // R5 non-shared mismatch
        '{32'h0006_3C00, 8'h07, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0,         1'b0, 1'b0, 8'd7},  // R7 two ways match
        '{32'hFFFF_FBFF, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 8'd11}, // R11 top set, top tag
        '{32'hFFFF_FBFF, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0, 8'd8},  // R8 write to RO
        '{32'hFFFF_FBFF, 8'hFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0, 8'd8},  // R8 user to privileged
        '{32'h0000_5000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,         1'b0, 1'b0, 8'd6}   // R6 empty set
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [1:0] way, input logic [4:0] set,
                       input logic [14:0] hi, input logic [1:0] lo,
                       input logic [7:0] asid, input logic v,
                       input logic [21:0] ppn, input logic [1:0] prot,
                       input logic sz, input logic c, input logic d, input logic sh);
        @(negedge clk);
        wr_en = 1'b1; wr_way = way; wr_set = set; wr_vpn_hi = hi; wr_vpn_lo = lo;
        wr_asid = asid; wr_valid = v; wr_ppn = ppn; wr_prot = prot;
        wr_size = sz; wr_cache = c; wr_dirty = d; wr_shared = sh;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [31:0] va, input logic [7:0] asid,
                        input logic wr, input logic usr);
        @(negedge clk);
        lk_va = va; lk_asid = asid; lk_write = wr; lk_user = usr;
        #2;
    endtask

    initial begin
        repeat (25000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_way = '0; wr_set = '0; wr_vpn_hi = '0;
        wr_vpn_lo = '0; wr_asid = '0; wr_valid = 1'b0; wr_ppn = '0; wr_prot = '0;
        wr_size = 1'b0; wr_cache = 1'b0; wr_dirty = 1'b0; wr_shared = 1'b0;
        lk_va = 32'h0002_1523; lk_asid = 8'h05; lk_write = 1'b0; lk_user = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #2;
        chk("R2", "reset miss", 32'(miss), 32'd1);
        chk("R2", "reset hit", 32'(hit), 32'd0);

        put(2'd0, 5'd1,  15'h0001, 2'b01, 8'h05, 1'b1, 22'h000100, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0);
        put(2'd1, 5'd1,  15'h0001, 2'b01, 8'h05, 1'b0, 22'h000999, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0); // R6 invalid twin
        put(2'd1, 5'd2,  15'h0003, 2'b00, 8'h07, 1'b1, 22'h000207, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1);
        put(2'd2, 5'd3,  15'h0003, 2'b00, 8'h07, 1'b1, 22'h000400, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0);
        put(2'd3, 5'd3,  15'h0003, 2'b11, 8'h07, 1'b1, 22'h000500, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0);
        put(2'd0, 5'd31, 15'h7FFF, 2'b10, 8'hFF, 1'b1, 22'h3FFFFF, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            look(VECS[i].va, VECS[i].asid, VECS[i].wr, VECS[i].usr);
            chk(tag, "hit",   32'(hit),         32'(VECS[i].e_hit));
            chk(tag, "miss",  32'(miss),        32'(VECS[i].e_miss));
            chk(tag, "multi", 32'(multi_hit),   32'(VECS[i].e_multi));
            chk(tag, "pa",    pa,               VECS[i].e_pa);
            chk(tag, "viol",  32'(prot_viol),   32'(VECS[i].e_viol));
            chk(tag, "fw",    32'(first_write), 32'(VECS[i].e_fw));
        end

        // R10: attributes of the shared 4 KB entry
        look(32'h0006_2ABC, 8'h99, 1'b0, 1'b0);
        chk("R10", "prot",   32'(attr_prot),   32'd2);
        chk("R10", "size",   32'(attr_size),   32'd1);
        chk("R10", "cache",  32'(attr_cache),  32'd0);
        chk("R10", "dirty",  32'(attr_dirty),  32'd0);
        chk("R10", "shared", 32'(attr_shared), 32'd1);
        // R10 / R7: attributes zero during a multiple match
        look(32'h0006_3C00, 8'h07, 1'b0, 1'b0);
        chk("R7", "multi prot",  32'(attr_prot),  32'd0);
        chk("R7", "multi cache", 32'(attr_cache), 32'd0);

        // R1: overwrite one entry, neighbour in another way stays put
        put(2'd0, 5'd1, 15'h0001, 2'b01, 8'h05, 1'b1, 22'h0002AA, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0);
        look(32'h0002_1523, 8'h05, 1'b0, 1'b0);
        chk("R1", "overwrite pa", pa, 32'h000A_A923);
        chk("R1", "overwrite hit", 32'(hit), 32'd1);
        look(32'h0006_2ABC, 8'h01, 1'b0, 1'b0);
        chk("R1", "other entry pa", pa, 32'h0008_1ABC);

        // R2: reset drops every entry
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        look(32'hFFFF_FBFF, 8'hFF, 1'b0, 1'b0);
        chk("R2", "post reset miss", 32'(miss), 32'd1);
        look(32'h0002_1523, 8'h05, 1'b0, 1'b0);
        chk("R2", "post reset hit", 32'(hit), 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule